// File: doc/BRIEF.md
# RV32 Integer ALU

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a base RISC-V integer pipeline. It takes two operands and a 4-bit decoded operation code and returns a 32-bit result. The operation code alone decides whether the operands are treated as signed or unsigned. Register contents carry no type of their own.

Operand B is either a register value or an immediate. An immediate reaches the unit already sign-extended from 12 bits, so the unit never sees the raw 12-bit field. There is no subtract-immediate operation: code that needs to subtract a constant uses add with the negated immediate. Shift amounts come only from the low five bits of operand B, read as unsigned. Add and subtract wrap modulo 2^32 and produce no flags.

Top module: `rv32_alu`

## Requirements
- R1: Operation code 4'h0 (add) gives `a_i + b_i` modulo 2^32, with no overflow indication.
- R2: Operation code 4'h8 (subtract) gives `a_i - b_i` modulo 2^32.
- R3: Operation codes 4'h7, 4'h6 and 4'h4 give the bitwise AND, OR and XOR of the operands.
- R4: Operation code 4'h1 (left shift) shifts `a_i` left by `b_i[4:0]` and fills the vacated low bits with zeros. Bits 31:5 of `b_i` have no effect.
- R5: Operation code 4'h5 (logical right shift) shifts `a_i` right by `b_i[4:0]` and fills the vacated high bits with zeros. Bits 31:5 of `b_i` have no effect.
- R6: Operation code 4'hD (arithmetic right shift) shifts `a_i` right by `b_i[4:0]` and fills the vacated high bits with copies of `a_i[31]`.
- R7: Operation code 4'h2 (set-less-than) returns 32'd1 when `a_i` is less than `b_i` as signed two's complement values, and 32'd0 otherwise. Bits 31:1 of the result are always zero.
- R8: A sign-extended 12-bit immediate on `b_i` (range -2048..2047) combines correctly with add and with set-less-than. Adding a negative immediate lowers the result.
- R9: Every operation code not listed above (4'h3, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF) yields a result of zero.
- R10: The result depends only on the current inputs. It follows a change of any input with no clock edge, and it holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Decoded operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B: register value or sign-extended immediate |
| result_o | output | 32 | Operation result |

## Verification
The unit holds no state, so any internal fault appears on `result_o` in the same time step as the input that exposes it. There is no latency to account for. A miswired shifter stage shows up only for shift amounts that have the corresponding bit set. For that reason, every one of the 32 shift amounts is applied, both with and without high garbage bits in `b_i`. A wrong signed-compare path shows up only when the operand signs differ or the difference crosses the overflow boundary, so those corner operands are driven deliberately.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'h0,
    OP_SLL = 4'h1,
    OP_SLT = 4'h2,
    OP_XOR = 4'h4,
    OP_SRL = 4'h5,
    OP_OR  = 4'h6,
    OP_AND = 4'h7,
    OP_SUB = 4'h8,
    OP_SRA = 4'hD
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_o
);
  logic [W-1:0] b_eff;

  assign b_eff = b_i ^ {W{sub_i}};
  assign sum_o = a_i + b_eff + W'(sub_i);
  // Signs differ: A is less exactly when A is negative; otherwise the difference sign decides.
  assign lt_o  = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : sum_o[W-1];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] src;
  logic [W-1:0] stage [SW+1];
  logic         fill;

  assign fill = arith_i & ~left_i & data_i[W-1];

  // Left shifts reuse the right-shift stages on bit-reversed data.
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign src[i] = left_i ? data_i[W-1-i] : data_i[i];
  end

  assign stage[0] = src;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = shamt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign data_o[i] = left_i ? stage[SW][W-1-i] : stage[SW][i];
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'b11:   y_o = a_i & b_i;
      2'b10:   y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/rv32_alu.sv
module rv32_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    result_o
);
  localparam int unsigned SW = $clog2(W);

  logic [W-1:0] sum, shifted, bitwise;
  logic         lt, do_sub, shift_left, shift_arith;

  assign do_sub      = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign shift_left  = (op_i == OP_SLL);
  assign shift_arith = (op_i == OP_SRA);

  alu_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (do_sub),
    .sum_o (sum),
    .lt_o  (lt)
  );

  alu_shifter #(.W(W), .SW(SW)) u_shifter (
    .data_i  (a_i),
    .shamt_i (b_i[SW-1:0]),
    .left_i  (shift_left),
    .arith_i (shift_arith),
    .data_o  (shifted)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (op_i[1:0]),
    .y_o   (bitwise)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB:         result_o = sum;
      OP_SLT:                 result_o = W'(lt);
      OP_SLL, OP_SRL, OP_SRA: result_o = shifted;
      OP_XOR, OP_OR, OP_AND:  result_o = bitwise;
      default:                result_o = '0;
    endcase
  end
endmodule

// File: rtl/rv32_alu_chk.sv
module rv32_alu_chk
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [W-1:0]    result_o
);
  localparam int unsigned SW = $clog2(W);

  logic [W-1:0] low_mask, high_mask;

  assign low_mask  = (W'(1) << b_i[SW-1:0]) - W'(1);
  assign high_mask = ~({W{1'b1}} >> b_i[SW-1:0]);

  always_comb begin
    // R1
    if (op_i == OP_ADD) add_inverse_chk: assert (result_o - b_i == a_i);
    // R2
    if (op_i == OP_SUB) sub_inverse_chk: assert (result_o + b_i == a_i);
    // R3
    if (op_i == OP_AND) and_subset_chk: assert ((result_o & ~a_i) == '0);
    // R3
    if (op_i == OP_OR) or_superset_chk: assert ((a_i & ~result_o) == '0);
    // R4
    if (op_i == OP_SLL) sll_zero_fill_chk: assert ((result_o & low_mask) == '0);
    // R5
    if (op_i == OP_SRL) srl_zero_fill_chk: assert ((result_o & high_mask) == '0);
    // R6
    if (op_i == OP_SRA) sra_sign_fill_chk: assert ((result_o & high_mask) == (a_i[W-1] ? high_mask : '0));
    // R7
    if (op_i == OP_SLT) slt_bool_chk: assert (result_o[W-1:1] == '0);
    // R9
    if (!(op_i inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLL, OP_SRL, OP_SRA, OP_SLT}))
      unused_zero_chk: assert (result_o == '0);
  end
endmodule

bind rv32_alu rv32_alu_chk #(.W(W)) u_chk (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o)
);

// File: tb/rv32_alu_tb.sv
module rv32_alu_tb;
  logic        clk;
  logic        rst_ni;
  logic [3:0]  op;
  logic [31:0] a, b, res;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  rv32_alu u_dut (.op_i(op), .a_i(a), .b_i(b), .result_o(res));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] ref_alu(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      4'h0: return x + y;
      4'h8: return x - y;
      4'h7: return x & y;
      4'h6: return x | y;
      4'h4: return x ^ y;
      4'h1: return x << y[4:0];
      4'h5: return x >> y[4:0];
      4'hD: return 32'($signed(x) >>> y[4:0]);
      4'h2: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] exp;
    op = o; a = x; b = y;
    #1;
    exp = ref_alu(o, x, y);
    checks++;
    if (res !== exp) begin
      failures++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", req, o, x, y, res, exp);
    end
  endtask

  task automatic t_initial();
    check("R1", 4'h0, 32'd0, 32'd0);
  endtask

  task automatic t_add();
    check("R1", 4'h0, 32'd5, 32'd7);
    check("R1", 4'h0, 32'hFFFF_FFFF, 32'd1);
    check("R1", 4'h0, 32'h7FFF_FFFF, 32'd1);
    for (int i = 0; i < 20; i++) check("R1", 4'h0, $urandom, $urandom);
  endtask

  task automatic t_sub();
    check("R2", 4'h8, 32'd3, 32'd5);
    check("R2", 4'h8, 32'h8000_0000, 32'd1);
    check("R2", 4'h8, 32'd0, 32'd0);
    for (int i = 0; i < 20; i++) check("R2", 4'h8, $urandom, $urandom);
  endtask

  task automatic t_logic();
    check("R3", 4'h7, 32'hF0F0_1234, 32'h0FF0_FF00);
    check("R3", 4'h6, 32'hF0F0_1234, 32'h0FF0_FF00);
    check("R3", 4'h4, 32'hF0F0_1234, 32'h0FF0_FF00);
    for (int i = 0; i < 10; i++) begin
      check("R3", 4'h7, $urandom, $urandom);
      check("R3", 4'h6, $urandom, $urandom);
      check("R3", 4'h4, $urandom, $urandom);
    end
  endtask

  task automatic t_shifts();
    for (int s = 0; s < 32; s++) begin
      check("R4", 4'h1, 32'h8000_0001, 32'(s));
      check("R4", 4'h1, 32'hDEAD_BEEF, 32'hFFFF_FFE0 | 32'(s));
      check("R5", 4'h5, 32'h8000_0001, 32'(s));
      check("R5", 4'h5, 32'hDEAD_BEEF, 32'h1234_5660 | 32'(s));
      check("R6", 4'hD, 32'h8000_0001, 32'(s));
      check("R6", 4'hD, 32'h7EAD_BEEF, 32'hABCD_EF00 | 32'(s));
      check("R6", 4'hD, 32'hF000_0000, 32'hFFFF_FFE0 | 32'(s));
    end
  endtask

  task automatic t_slt();
    check("R7", 4'h2, 32'hFFFF_FFFF, 32'd1);
    check("R7", 4'h2, 32'd1, 32'hFFFF_FFFF);
    check("R7", 4'h2, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R7", 4'h2, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R7", 4'h2, 32'd9, 32'd9);
    check("R7", 4'h2, 32'd8, 32'd9);
    for (int i = 0; i < 20; i++) check("R7", 4'h2, $urandom, $urandom);
  endtask

  task automatic t_imm();
    check("R8", 4'h0, 32'd100, 32'hFFFF_F800);
    check("R8", 4'h0, 32'd100, 32'h0000_07FF);
    check("R8", 4'h0, 32'd10, 32'hFFFF_FFFD);
    check("R8", 4'h2, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
    check("R8", 4'h2, 32'd0, 32'hFFFF_F800);
  endtask

  task automatic t_unused();
    logic [3:0] codes [7] = '{4'h3, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF};
    foreach (codes[i]) check("R9", codes[i], 32'hFFFF_FFFF, 32'h8000_0001);
  endtask

  task automatic t_comb();
    check("R10", 4'h0, 32'd1, 32'd2);
    b = 32'd40; #1;
    checks++;
    if (res !== 32'd41) begin
      failures++;
      $display("FAIL R10 actual=%h expected=%h", res, 32'd41);
    end
    op = 4'h4; #1;
    checks++;
    if (res !== 32'd41) begin
      failures++;
      $display("FAIL R10 actual=%h expected=%h", res, 32'd41);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    op = '0; a = '0; b = '0;
    #25 rst_ni = 1'b1;
    t_initial();
    t_add();
    t_sub();
    t_logic();
    t_shifts();
    t_slt();
    t_imm();
    t_unused();
    t_comb();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule